// File: doc/BRIEF.md
# FM Synthesizer Port Front End

This block sits between a byte-wide I/O port window and one or two FM synthesizer cores. It decodes a 4-bit port offset into address-port and data-port accesses. It latches the register index written to an address port and turns each data-port write into a register write command for the right core, or for the timer unit beside that core. For reads, it assembles the status byte.

The front end has four operating modes. Solo mode drives one older two-operator core through an 8-bit register index. Pair mode drives two older cores side by side: port bits pick one side or both, and values are rewritten to stay compatible. Banked mode drives one newer core through a 9-bit index whose bank comes from port bit 1. Auxiliary mode is banked mode plus a small control register window, which an escape code on the control address port opens and closes.

Every command and every read byte is registered. Each result appears one clock after the strobe that caused it.

Top module: `fm_port_front`

## Requirements
- R1: A strobe on an odd port offset is a data write. A strobe on an even offset is an address write. A data write produces at most one command per side, registered, and valid for exactly the one cycle after the strobe.
- R2: In solo mode (mode 0), an address write latches {0, data} as a 9-bit index, whatever the port. A data write to index 0x02, 0x03 or 0x04 goes to timer 0, with the timer select set to index−2. Every other index goes to core 0 unchanged. Side 1 outputs never fire outside pair mode.
- R3: In banked mode (mode 2), and in auxiliary mode when the control window does not claim the access, an address write latches {port[1], data}. Timer routing applies only to full indices 0x002–0x004.
- R4: In pair mode (mode 1), an access with port[3]=0 addresses side port[1]. An access with port[3]=1 addresses both sides. Each side keeps its own 8-bit latched index.
- R5: In pair mode, a side drops a data write to index 0x05. For index 0xE0 or above, the value is masked to its low 2 bits.
- R6: In pair mode, a value for index 0xC0–0xC8 keeps its low nibble, and its high nibble is forced to 0x5 on side 0 and 0xA on side 1. Side 1 commands carry address bit 8 set.
- R7: In pair mode, data for indices 0x02–0x04 goes to that side's timer output and not to its core output.
- R8: In the cycle after the mode becomes pair mode (including out of reset), core 0 receives a write of 0x01 to address 0x105.
- R9: In auxiliary mode (mode 3), an address write of 0xFF to offset 0xA opens the control window, and 0xFE closes it. While the window is open, any other value written to offset 0xA selects the control index. None of these latches a core index.
- R10: With the window open, a data write to offset 0xB stores the left volume at index 0x09 and the right volume at index 0x0A, and issues no core command. Both volumes reset to 0xFF.
- R11: With the window open, reading offset 0xA returns 0x00. Reading offset 0xB returns 0x70 for index 0x00, 0x71 for index 0x15, the stored volume for index 0x09 or 0x0A, and 0xFF for any other index.
- R12: Outside pair mode, a read with nonzero port[1:0] returns 0xFF. Otherwise it returns stat0, ORed with 0x06 in solo mode.
- R13: In pair mode, a read of an odd offset returns 0xFF. A read of an even offset returns the status of side port[1], ORed with 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 solo, 1 pair, 2 banked, 3 auxiliary |
| port | input | 4 | Low bits of the accessed port |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| stat0 | input | 8 | Status from side 0 timer unit |
| stat1 | input | 8 | Status from side 1 timer unit |
| c0_we | output | 1 | Core 0 register write |
| c0_addr | output | 9 | Core 0 register address |
| c0_data | output | 8 | Core 0 register value |
| c1_we | output | 1 | Core 1 register write |
| c1_addr | output | 9 | Core 1 register address |
| c1_data | output | 8 | Core 1 register value |
| t0_we | output | 1 | Timer 0 register write |
| t0_sel | output | 2 | Timer 0 register select (index−2) |
| t0_data | output | 8 | Timer 0 value |
| t1_we | output | 1 | Timer 1 register write |
| t1_sel | output | 2 | Timer 1 register select (index−2) |
| t1_data | output | 8 | Timer 1 value |
| rdata | output | 8 | Read data, held until the next read |
| vol_l | output | 8 | Left volume control register |
| vol_r | output | 8 | Right volume control register |

## Verification
Every write command, timer command and read byte passes through one register, so each result is due one cycle after its strobe. The mode-entry write is due one cycle after the mode changes. The bench drives each strobe on a falling edge and drops it on the next falling edge, then samples at once. That sample falls half a period after the capturing rising edge and before the one-cycle pulse ends. Index latches are written one access before the data write that uses them, so each vector depends only on registers that have already settled.

// File: rtl/fm_port_front.sv
module fm_port_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [3:0] port,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  input  logic [7:0] stat0,
  input  logic [7:0] stat1,
  output logic       c0_we,
  output logic [8:0] c0_addr,
  output logic [7:0] c0_data,
  output logic       c1_we,
  output logic [8:0] c1_addr,
  output logic [7:0] c1_data,
  output logic       t0_we,
  output logic [1:0] t0_sel,
  output logic [7:0] t0_data,
  output logic       t1_we,
  output logic [1:0] t1_sel,
  output logic [7:0] t1_data,
  output logic [7:0] rdata,
  output logic [7:0] vol_l,
  output logic [7:0] vol_r
);
  localparam logic [1:0] M_SOLO = 2'd0;
  localparam logic [1:0] M_PAIR = 2'd1;
  localparam logic [1:0] M_AUX  = 2'd3;
  localparam logic [3:0] CTL_A  = 4'hA;
  localparam logic [3:0] CTL_D  = 4'hB;
  localparam logic [7:0] ESC_ON  = 8'hFF;
  localparam logic [7:0] ESC_OFF = 8'hFE;

  logic [8:0] idx_n;
  logic [7:0] idx_p0, idx_p1;
  logic       win_on, was_pair;
  logic [7:0] win_idx;

  function automatic logic is_tmr(input logic [8:0] r);
    return r >= 9'h002 && r <= 9'h004;
  endfunction

  function automatic logic [7:0] pair_val(input logic s, input logic [7:0] r, input logic [7:0] v);
    if (r >= 8'hE0) return {6'd0, v[1:0]};
    if (r >= 8'hC0 && r <= 8'hC8) return {(s ? 4'hA : 4'h5), v[3:0]};
    return v;
  endfunction

  wire is_pair = mode == M_PAIR;
  wire is_old  = ~mode[1];
  wire is_aux  = mode == M_AUX;
  wire a_wr    = wr_en & ~port[0];
  wire d_wr    = wr_en &  port[0];
  wire on_ca   = is_aux & (port == CTL_A);
  wire on_cd   = is_aux & (port == CTL_D);
  wire esc     = (wdata == ESC_ON) | (wdata == ESC_OFF);
  wire ctl_aw  = a_wr & on_ca & (esc | win_on);
  wire ctl_dw  = d_wr & on_cd & win_on;
  wire n_aw    = a_wr & ~is_pair & ~ctl_aw;
  wire n_dw    = d_wr & ~is_pair & ~ctl_dw;
  wire hit0    = is_pair & (port[3] | ~port[1]);
  wire hit1    = is_pair & (port[3] |  port[1]);
  wire p0_dw   = d_wr & hit0 & (idx_p0 != 8'h05);
  wire p1_dw   = d_wr & hit1 & (idx_p1 != 8'h05);
  wire p0_tm   = is_tmr({1'b0, idx_p0});
  wire p1_tm   = is_tmr({1'b0, idx_p1});
  wire n_tm    = is_tmr(idx_n);
  wire entry   = is_pair & ~was_pair;

  logic [7:0] ctl_rd;
  always_comb begin
    case (win_idx)
      8'h00:   ctl_rd = 8'h70;
      8'h09:   ctl_rd = vol_l;
      8'h0A:   ctl_rd = vol_r;
      8'h15:   ctl_rd = 8'h71;
      default: ctl_rd = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_n <= '0; idx_p0 <= '0; idx_p1 <= '0;
      win_on <= 1'b0; win_idx <= '0; was_pair <= 1'b0;
      vol_l <= 8'hFF; vol_r <= 8'hFF;
    end else begin
      was_pair <= is_pair;
      if (n_aw) idx_n <= is_old ? {1'b0, wdata} : {port[1], wdata};
      if (a_wr & hit0) idx_p0 <= wdata;
      if (a_wr & hit1) idx_p1 <= wdata;
      if (ctl_aw) begin
        if (wdata == ESC_ON) win_on <= 1'b1;
        else if (wdata == ESC_OFF) win_on <= 1'b0;
        else win_idx <= wdata;
      end
      if (ctl_dw && win_idx == 8'h09) vol_l <= wdata;
      if (ctl_dw && win_idx == 8'h0A) vol_r <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0_we <= 1'b0; c0_addr <= '0; c0_data <= '0;
      c1_we <= 1'b0; c1_addr <= '0; c1_data <= '0;
      t0_we <= 1'b0; t0_sel <= '0; t0_data <= '0;
      t1_we <= 1'b0; t1_sel <= '0; t1_data <= '0;
    end else begin
      c0_we <= 1'b0; c1_we <= 1'b0; t0_we <= 1'b0; t1_we <= 1'b0;
      if (entry) begin
        c0_we <= 1'b1; c0_addr <= 9'h105; c0_data <= 8'h01;
      end else if (n_dw & ~n_tm) begin
        c0_we <= 1'b1; c0_addr <= idx_n; c0_data <= wdata;
      end else if (p0_dw & ~p0_tm) begin
        c0_we <= 1'b1; c0_addr <= {1'b0, idx_p0}; c0_data <= pair_val(1'b0, idx_p0, wdata);
      end
      if (n_dw & n_tm) begin
        t0_we <= 1'b1; t0_sel <= idx_n[1:0] - 2'd2; t0_data <= wdata;
      end else if (p0_dw & p0_tm) begin
        t0_we <= 1'b1; t0_sel <= idx_p0[1:0] - 2'd2; t0_data <= wdata;
      end
      if (p1_dw & ~p1_tm) begin
        c1_we <= 1'b1; c1_addr <= {1'b1, idx_p1}; c1_data <= pair_val(1'b1, idx_p1, wdata);
      end
      if (p1_dw & p1_tm) begin
        t1_we <= 1'b1; t1_sel <= idx_p1[1:0] - 2'd2; t1_data <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'hFF;
    else if (rd_en) begin
      if (is_pair)                  rdata <= port[0] ? 8'hFF : ((port[1] ? stat1 : stat0) | 8'h06);
      else if (on_ca & win_on)      rdata <= 8'h00;
      else if (on_cd & win_on)      rdata <= ctl_rd;
      else if (port[1:0] != 2'b00)  rdata <= 8'hFF;
      else                          rdata <= (mode == M_SOLO) ? (stat0 | 8'h06) : stat0;
    end
  end
endmodule

// File: rtl/fm_port_front_chk.sv
module fm_port_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [3:0] port,
  input logic       wr_en,
  input logic       rd_en,
  input logic       c0_we,
  input logic [8:0] c0_addr,
  input logic [7:0] c0_data,
  input logic       c1_we,
  input logic [8:0] c1_addr,
  input logic [7:0] c1_data,
  input logic       t1_we,
  input logic [7:0] rdata,
  input logic [7:0] vol_l,
  input logic [7:0] vol_r
);
  logic seen_pair;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_pair <= 1'b0;
    else seen_pair <= (mode == 2'd1);
  end

  // R2
  solo_side1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode != 2'd1) |=> (!c1_we && !t1_we));

  // R5
  reg5_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c1_we |-> (c1_addr[7:0] != 8'h05));

  // R5
  wave_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_we && c1_addr[7:0] >= 8'hE0) |-> (c1_data[7:2] == 6'd0));

  // R6
  pan_side1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_we && c1_addr[7:0] >= 8'hC0 && c1_addr[7:0] <= 8'hC8) |-> (c1_data[7:4] == 4'hA));

  // R8
  pair_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !seen_pair) |=> (c0_we && c0_addr == 9'h105 && c0_data == 8'h01));

  // R10
  vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(vol_l) && $stable(vol_r)));

  // R13
  pair_odd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 2'd1 && port[0]) |=> (rdata == 8'hFF));
endmodule

bind fm_port_front fm_port_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .port(port), .wr_en(wr_en), .rd_en(rd_en),
  .c0_we(c0_we), .c0_addr(c0_addr), .c0_data(c0_data),
  .c1_we(c1_we), .c1_addr(c1_addr), .c1_data(c1_data),
  .t1_we(t1_we), .rdata(rdata), .vol_l(vol_l), .vol_r(vol_r)
);

// File: tb/fm_port_front_bench.sv
module fm_port_front_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, wr_en, rd_en;
  logic [1:0] mode;
  logic [3:0] port;
  logic [7:0] wdata, stat0, stat1;
  logic       c0_we, c1_we, t0_we, t1_we;
  logic [8:0] c0_addr, c1_addr;
  logic [7:0] c0_data, c1_data, t0_data, t1_data, rdata, vol_l, vol_r;
  logic [1:0] t0_sel, t1_sel;

  fm_port_front u_fm_port_front (
    .clk(clk), .rst_n(rst_n), .mode(mode), .port(port), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .stat0(stat0), .stat1(stat1),
    .c0_we(c0_we), .c0_addr(c0_addr), .c0_data(c0_data),
    .c1_we(c1_we), .c1_addr(c1_addr), .c1_data(c1_data),
    .t0_we(t0_we), .t0_sel(t0_sel), .t0_data(t0_data),
    .t1_we(t1_we), .t1_sel(t1_sel), .t1_data(t1_data),
    .rdata(rdata), .vol_l(vol_l), .vol_r(vol_r)
  );

  int applied = 0, bad = 0;
  bit done = 0;

  // {mode, addr port, addr value, data port, data value, c0 we/addr/data, c1 we/addr/data}
  localparam int NV = 14;
  localparam logic [61:0] VEC [NV] = '{
    {2'd0, 4'h0, 8'h20, 4'h1, 8'hAB, 1'b1, 9'h020, 8'hAB, 1'b0, 9'h000, 8'h00},
    {2'd0, 4'h2, 8'hE1, 4'h3, 8'hFF, 1'b1, 9'h0E1, 8'hFF, 1'b0, 9'h000, 8'h00},
    {2'd0, 4'h0, 8'h05, 4'h1, 8'h01, 1'b1, 9'h005, 8'h01, 1'b0, 9'h000, 8'h00},
    {2'd2, 4'h2, 8'h05, 4'h3, 8'h01, 1'b1, 9'h105, 8'h01, 1'b0, 9'h000, 8'h00},
    {2'd2, 4'h0, 8'hC3, 4'h1, 8'h3F, 1'b1, 9'h0C3, 8'h3F, 1'b0, 9'h000, 8'h00},
    {2'd2, 4'h2, 8'h02, 4'h3, 8'h11, 1'b1, 9'h102, 8'h11, 1'b0, 9'h000, 8'h00},
    {2'd3, 4'hA, 8'h40, 4'hB, 8'h12, 1'b1, 9'h140, 8'h12, 1'b0, 9'h000, 8'h00},
    {2'd1, 4'h0, 8'hC2, 4'h1, 8'h07, 1'b1, 9'h0C2, 8'h57, 1'b0, 9'h000, 8'h00},
    {2'd1, 4'h2, 8'hC8, 4'h3, 8'hF3, 1'b0, 9'h000, 8'h00, 1'b1, 9'h1C8, 8'hA3},
    {2'd1, 4'h8, 8'hE4, 4'h9, 8'hFE, 1'b1, 9'h0E4, 8'h02, 1'b1, 9'h1E4, 8'h02},
    {2'd1, 4'h8, 8'h05, 4'h9, 8'h00, 1'b0, 9'h000, 8'h00, 1'b0, 9'h000, 8'h00},
    {2'd1, 4'h0, 8'hB0, 4'h9, 8'h31, 1'b1, 9'h0B0, 8'h31, 1'b0, 9'h000, 8'h00},
    {2'd1, 4'h2, 8'hC9, 4'h3, 8'h8F, 1'b0, 9'h000, 8'h00, 1'b1, 9'h1C9, 8'h8F},
    {2'd1, 4'h0, 8'hDF, 4'h1, 8'hFF, 1'b1, 9'h0DF, 8'hFF, 1'b0, 9'h000, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h, want %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk); port = p; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p);
    @(negedge clk); port = p; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang, want completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; mode = 2'd0;
    port = 4'h0; wdata = 8'h00; stat0 = 8'h40; stat1 = 8'h20;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 R10 reset state
    chk("R1 reset c0_we", c0_we, 1'b0);
    chk("R1 reset c1_we", c1_we, 1'b0);
    chk("R10 reset vol_l", vol_l, 8'hFF);
    chk("R10 reset vol_r", vol_r, 8'hFF);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      v = VEC[i];
      if (mode != v[61:60]) begin
        mode = v[61:60];
        idle(3);
      end
      wr(v[59:56], v[55:48]);
      wr(v[47:44], v[43:36]);
      chk("R4/R5/R6 c0_we", c0_we, v[35]);
      if (v[35]) begin
        chk("R2/R3/R6 c0_addr", c0_addr, v[34:26]);
        chk("R5/R6 c0_data", c0_data, v[25:18]);
      end
      chk("R4/R5 c1_we", c1_we, v[17]);
      if (v[17]) begin
        chk("R6 c1_addr", c1_addr, v[16:8]);
        chk("R5/R6 c1_data", c1_data, v[7:0]);
      end
      idle(1);
      chk("R1 single pulse c0", c0_we, 1'b0);
    end

    // R8 entering pair mode
    mode = 2'd0; idle(3);
    mode = 2'd1;
    @(negedge clk);
    chk("R8 entry we", c0_we, 1'b1);
    chk("R8 entry addr", c0_addr, 9'h105);
    chk("R8 entry data", c0_data, 8'h01);
    @(negedge clk);
    chk("R8 entry once", c0_we, 1'b0);

    // R7 pair timer on side 1
    wr(4'h2, 8'h03); wr(4'h3, 8'h55);
    chk("R7 t1_we", t1_we, 1'b1);
    chk("R7 t1_sel", t1_sel, 2'd1);
    chk("R7 t1_data", t1_data, 8'h55);
    chk("R7 no c1", c1_we, 1'b0);

    // R13 pair reads
    rd(4'h2); chk("R13 side1 status", rdata, 8'h26);
    rd(4'h0); chk("R13 side0 status", rdata, 8'h46);
    rd(4'h3); chk("R13 odd read", rdata, 8'hFF);

    // R2 solo timer and reads
    mode = 2'd0; idle(2);
    wr(4'h0, 8'h04); wr(4'h1, 8'h80);
    chk("R2 t0_we", t0_we, 1'b1);
    chk("R2 t0_sel", t0_sel, 2'd2);
    chk("R2 t0_data", t0_data, 8'h80);
    chk("R2 no c0", c0_we, 1'b0);
    chk("R2 no t1", t1_we, 1'b0);
    rd(4'h0); chk("R12 solo status", rdata, 8'h46);
    rd(4'h1); chk("R12 solo high port", rdata, 8'hFF);

    // R12 banked reads
    mode = 2'd2; idle(2);
    rd(4'h0); chk("R12 banked status", rdata, 8'h40);
    rd(4'h2); chk("R12 banked high port", rdata, 8'hFF);

    // R9 R10 R11 auxiliary window
    mode = 2'd3; idle(2);
    rd(4'hB); chk("R12 window closed read", rdata, 8'hFF);
    wr(4'hA, 8'hFF);
    rd(4'hA); chk("R11 ctl addr read", rdata, 8'h00);
    wr(4'hA, 8'h09); wr(4'hB, 8'h1C);
    chk("R10 no core write", c0_we, 1'b0);
    chk("R10 vol_l", vol_l, 8'h1C);
    rd(4'hB); chk("R11 vol_l read", rdata, 8'h1C);
    wr(4'hA, 8'h0A); wr(4'hB, 8'h05);
    chk("R10 vol_r", vol_r, 8'h05);
    chk("R10 vol_l kept", vol_l, 8'h1C);
    rd(4'hB); chk("R11 vol_r read", rdata, 8'h05);
    wr(4'hA, 8'h00); rd(4'hB); chk("R11 idx 00", rdata, 8'h70);
    wr(4'hA, 8'h15); rd(4'hB); chk("R11 idx 15", rdata, 8'h71);
    wr(4'hA, 8'h33); rd(4'hB); chk("R11 other idx", rdata, 8'hFF);
    wr(4'hA, 8'hFE);
    rd(4'hA); chk("R9 closed ctl addr read", rdata, 8'hFF);
    wr(4'hA, 8'h09); wr(4'hB, 8'h22);
    chk("R9 closed routes to core", c0_we, 1'b1);
    chk("R9 closed addr", c0_addr, 9'h109);
    chk("R9 closed data", c0_data, 8'h22);
    chk("R9 closed vol_l", vol_l, 8'h1C);

    idle(2);
    finish_run();
  end
endmodule